// File: doc/BRIEF.md
# Bitmap Packet-Identifier Filter

This block sits in a transport-stream byte path and forwards or discards whole packets. Each packet arrives one byte per accepted cycle, its first byte marked by a start flag. The first eight bytes are packed into a 64-bit word, with the first byte in the top bits. A programmable bit slice of that word forms the packet identifier (PID). The PID selects one bit of a locally held lookup table, and that bit decides whether the packet goes out.

The packet bytes are held in a small commit buffer until the decision is known. A forwarded packet leaves with its bytes unchanged and in order. A discarded packet leaves no trace on the output. A configuration register holds the filter enable, the slice offset and the slice width. A word-wide write port loads the table. Writes to either one never change the verdict on a packet that has already started.

Top module: `pid_bitmap_filter`

## Requirements
- R1: After reset no byte is output, every table bit is zero, and the configuration is filtering enabled, width 13, offset 40.
- R2: With bytes b0..b7 packed as the word {b0,b1,...,b7}, the PID is word bits (offset+width-1) down to offset, with width 0 giving PID 0. Bits above bit 63 read as zero.
- R3: Table word `a`, bit `j` holds the verdict for PID a*WORD_W+j. A one forwards the packet and a zero drops it.
- R4: With filtering enabled and the PID's bit clear, no byte of the packet appears at the output, so an all-zero table drops every packet.
- R5: With the enable field cleared, every packet is forwarded whatever the table holds.
- R6: A forwarded packet comes out complete, bytes unchanged and in input order, with `out_sop` on its first byte only.
- R7: The configuration word has the offset in bits [5:0], the width in bits [11:8] and the enable in bit 15. Widths above PID_W yield the low PID_W bits of the slice. The configuration is captured at each packet's first byte, so a write in or after that cycle acts from the next packet.
- R8: A table write made between a packet's first byte and its eighth byte is queued, up to WQ_DEPTH entries. Queued writes are applied in order once the verdict is taken, so they act from the next packet.
- R9: Bytes that arrive outside a packet, before any start flag, are ignored.
- R10: Back-to-back packets at one byte per cycle never overflow the internal buffer, and every forwarded byte is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_data | input | 8 | Input byte |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration word (offset [5:0], width [11:8], enable [15]) |
| tbl_we | input | 1 | Table word write strobe |
| tbl_addr | input | TBL_AW (8) | Table word index |
| tbl_wdata | input | WORD_W (32) | Table word value |
| out_valid | output | 1 | Output byte present |
| out_sop | output | 1 | Output byte is the first of a packet |
| out_data | output | 8 | Output byte |

## Verification
The bench builds the filter with PKT_LEN=12 and the defaults PID_W=13, WORD_W=32, FIFO_DEPTH=16 and WQ_DEPTH=4. The short packet length lets hundreds of packets run, and table and configuration writes can land on every byte position, both inside the header window and after it. The full 13-bit PID keeps all 256 table words reachable. Random offsets up to 63 and widths up to 15 push the slice past bit 63 and past the PID width, and gapless streams of forwarded packets load the buffer at its worst case.

// File: rtl/pbf_pkg.sv
package pbf_pkg;

    // Number of leading packet bytes assembled for the identifier slice.
    localparam int HDR_BYTES = 8;

    typedef struct packed {
        logic       sop;
        logic [7:0] data;
    } ent_t;

    typedef struct packed {
        logic       en;
        logic [3:0] nbits;
        logic [5:0] offs;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{en: 1'b1, nbits: 4'd13, offs: 6'd40};

    function automatic cfg_t cfg_decode(input logic [15:0] w);
        cfg_t c;
        c.en    = w[15];
        c.nbits = w[11:8];
        c.offs  = w[5:0];
        return c;
    endfunction

    // Bits (off+nb-1) down to off of w, zero above bit 63, at most 16 bits wide.
    function automatic logic [15:0] slice_bits(input logic [63:0] w,
                                               input logic [5:0]  off,
                                               input logic [3:0]  nb);
        logic [16:0] m;
        m = (17'd1 << nb) - 17'd1;
        return 16'(w >> off) & m[15:0];
    endfunction

endpackage

// File: rtl/pbf_table.sv
module pbf_table #(
    parameter int PID_W    = 13,
    parameter int WORD_W   = 32,
    parameter int WQ_DEPTH = 4,
    localparam int NWORDS  = (1 << PID_W) / WORD_W,
    localparam int AW      = $clog2(NWORDS),
    localparam int BW      = $clog2(WORD_W),
    localparam int QW      = $clog2(WQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PID_W-1:0]  look_pid,
    output logic              look_hit,
    output logic [QW-1:0]     wq_count
);
    typedef struct packed {
        logic [AW-1:0]     a;
        logic [WORD_W-1:0] d;
    } wq_t;

    logic [WORD_W-1:0] words [NWORDS];
    wq_t               q     [WQ_DEPTH];
    wq_t               q_n   [WQ_DEPTH];
    wq_t               head;
    logic [QW-1:0]     cnt, cnt_n;
    logic              direct, pop;

    always_comb begin
        q_n    = q;
        cnt_n  = cnt;
        direct = 1'b0;
        pop    = 1'b0;
        head   = q[0];
        if (!hold && cnt != '0) begin
            pop = 1'b1;
            for (int i = 0; i < WQ_DEPTH - 1; i++) q_n[i] = q[i+1];
            q_n[WQ_DEPTH-1] = '0;
            cnt_n = cnt - 1'b1;
        end
        if (wr_en) begin
            if (!hold && cnt == '0) begin
                direct = 1'b1;
            end else if (cnt_n < QW'(WQ_DEPTH)) begin
                for (int i = 0; i < WQ_DEPTH; i++)
                    if (QW'(i) == cnt_n) q_n[i] = '{a: wr_addr, d: wr_data};
                cnt_n = cnt_n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) words[i] <= '0;
        end else if (direct) begin
            words[wr_addr] <= wr_data;
        end else if (pop) begin
            words[head.a] <= head.d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < WQ_DEPTH; i++) q[i] <= '0;
        end else begin
            cnt <= cnt_n;
            q   <= q_n;
        end
    end

    assign look_hit = words[look_pid[PID_W-1:BW]][look_pid[BW-1:0]];
    assign wq_count = cnt;

endmodule

// File: rtl/pbf_framer.sv
module pbf_framer
    import pbf_pkg::*;
#(
    parameter int PID_W   = 13,
    parameter int PKT_LEN = 188,
    localparam int CW     = $clog2(PKT_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    input  cfg_t             cfg_cur,
    input  logic             look_hit,
    output logic [PID_W-1:0] look_pid,
    output logic             hold,
    output logic             wr_go,
    output logic             commit,
    output logic             rewind,
    output logic             restart
);
    logic [CW-1:0] cnt, pos;
    logic          in_pkt, keep, accept, decide, tail, pass;
    logic [55:0]   hdr;
    logic [63:0]   hdr_full;
    cfg_t          act;

    always_comb begin
        accept   = in_valid && (in_sop || in_pkt);
        pos      = in_sop ? '0 : cnt;
        hdr_full = {hdr, in_data};
        look_pid = PID_W'(slice_bits(hdr_full, act.offs, act.nbits));
        decide   = accept && (pos == CW'(HDR_BYTES - 1));
        tail     = accept && (pos > CW'(HDR_BYTES - 1));
        pass     = !act.en || look_hit;
        restart  = accept && in_sop;
        wr_go    = accept && ((pos < CW'(HDR_BYTES - 1)) || (decide && pass) || (tail && keep));
        commit   = (decide && pass) || (tail && keep);
        rewind   = decide && !pass;
        hold     = (in_pkt && cnt < CW'(HDR_BYTES)) || (in_valid && in_sop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            in_pkt <= 1'b0;
            keep   <= 1'b0;
            hdr    <= '0;
            act    <= CFG_RESET;
        end else if (accept) begin
            hdr <= hdr_full[55:0];
            if (in_sop) act <= cfg_cur;
            keep <= decide ? pass : (in_sop ? 1'b0 : keep);
            if (pos == CW'(PKT_LEN - 1)) begin
                cnt    <= '0;
                in_pkt <= 1'b0;
            end else begin
                cnt    <= pos + 1'b1;
                in_pkt <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pbf_buffer.sv
module pbf_buffer
    import pbf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_go,
    input  logic        commit,
    input  logic        rewind,
    input  logic        restart,
    input  ent_t        wr_ent,
    output logic        out_valid,
    output ent_t        out_ent,
    output logic [AW:0] fill
);
    ent_t        mem [DEPTH];
    logic [AW:0] wr, cm, rd, base;

    assign base = restart ? cm : wr;
    assign fill = wr - rd;

    always_ff @(posedge clk) begin
        if (wr_go) mem[base[AW-1:0]] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr        <= '0;
            cm        <= '0;
            rd        <= '0;
            out_valid <= 1'b0;
            out_ent   <= '0;
        end else begin
            if (wr_go) begin
                wr <= base + 1'b1;
                if (commit) cm <= base + 1'b1;
            end else if (rewind) begin
                wr <= cm;
            end
            out_valid <= (rd != cm);
            if (rd != cm) begin
                out_ent <= mem[rd[AW-1:0]];
                rd      <= rd + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pid_bitmap_filter.sv
module pid_bitmap_filter
    import pbf_pkg::*;
#(
    parameter int PID_W      = 13,
    parameter int WORD_W     = 32,
    parameter int PKT_LEN    = 188,
    parameter int FIFO_DEPTH = 16,
    parameter int WQ_DEPTH   = 4,
    localparam int TBL_AW    = $clog2((1 << PID_W) / WORD_W),
    localparam int BUF_AW    = $clog2(FIFO_DEPTH),
    localparam int WQ_W      = $clog2(WQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [7:0]        in_data,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    input  logic              tbl_we,
    input  logic [TBL_AW-1:0] tbl_addr,
    input  logic [WORD_W-1:0] tbl_wdata,
    output logic              out_valid,
    output logic              out_sop,
    output logic [7:0]        out_data
);
    cfg_t              cfg_reg;
    logic [PID_W-1:0]  look_pid;
    logic              look_hit, hold, wr_go, commit, rewind, restart;
    logic [BUF_AW:0]   fill;
    logic [WQ_W-1:0]   wq_count;
    ent_t              out_ent;

    always_ff @(posedge clk) begin
        if (rst)         cfg_reg <= CFG_RESET;
        else if (cfg_we) cfg_reg <= cfg_decode(cfg_wdata);
    end

    pbf_framer #(.PID_W(PID_W), .PKT_LEN(PKT_LEN)) framer_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .cfg_cur(cfg_reg), .look_hit(look_hit), .look_pid(look_pid), .hold(hold),
        .wr_go(wr_go), .commit(commit), .rewind(rewind), .restart(restart)
    );

    pbf_table #(.PID_W(PID_W), .WORD_W(WORD_W), .WQ_DEPTH(WQ_DEPTH)) table_i (
        .clk(clk), .rst(rst), .hold(hold), .wr_en(tbl_we), .wr_addr(tbl_addr),
        .wr_data(tbl_wdata), .look_pid(look_pid), .look_hit(look_hit), .wq_count(wq_count)
    );

    pbf_buffer #(.DEPTH(FIFO_DEPTH)) buffer_i (
        .clk(clk), .rst(rst), .wr_go(wr_go), .commit(commit), .rewind(rewind),
        .restart(restart), .wr_ent('{sop: in_sop, data: in_data}),
        .out_valid(out_valid), .out_ent(out_ent), .fill(fill)
    );

    assign out_sop  = out_ent.sop;
    assign out_data = out_ent.data;

endmodule

// File: rtl/pbf_checks.sv
module pbf_checks #(
    parameter int PKT_LEN    = 188,
    parameter int FIFO_DEPTH = 16,
    parameter int WQ_DEPTH   = 4,
    parameter int BUF_AW     = 4,
    parameter int QW         = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          out_valid,
    input logic          out_sop,
    input logic          wr_go,
    input logic          hold,
    input logic [BUF_AW:0] fill,
    input logic [QW-1:0] wq_count
);
    int ob_cnt;

    always_ff @(posedge clk) begin
        if (rst)            ob_cnt <= 0;
        else if (out_valid) ob_cnt <= out_sop ? 1 : ob_cnt + 1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    assert_pkt_start_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop) |-> (ob_cnt == 0 || ob_cnt == PKT_LEN));

    assert_pkt_body_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sop) |-> (ob_cnt != 0 && ob_cnt < PKT_LEN));

    assert_wq_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        int'(wq_count) <= WQ_DEPTH);

    assert_wq_defer_R8: assert property (@(posedge clk) disable iff (rst)
        (wq_count < $past(wq_count)) |-> !$past(hold));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        wr_go |-> int'(fill) < FIFO_DEPTH);

endmodule

bind pid_bitmap_filter pbf_checks #(
    .PKT_LEN(PKT_LEN), .FIFO_DEPTH(FIFO_DEPTH), .WQ_DEPTH(WQ_DEPTH),
    .BUF_AW(BUF_AW), .QW(WQ_W)
) chk_i (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_sop(out_sop),
    .wr_go(wr_go), .hold(hold), .fill(fill), .wq_count(wq_count)
);

// File: tb/pid_bitmap_filter_tb_top.sv
module pid_bitmap_filter_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PID_W = 13, WORD_W = 32, PKT_LEN = 12, FIFO_DEPTH = 16, WQ_DEPTH = 4;

    logic        clk = 1'b0, rst = 1'b1;
    logic        in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_addr = '0;
    logic [31:0] tbl_wdata = '0;
    logic        out_valid, out_sop;
    logic [7:0]  out_data;

    always #10 clk = ~clk;

    pid_bitmap_filter #(.PID_W(PID_W), .WORD_W(WORD_W), .PKT_LEN(PKT_LEN),
                        .FIFO_DEPTH(FIFO_DEPTH), .WQ_DEPTH(WQ_DEPTH)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data)
    );

    int          total = 0, bad = 0;
    string       req = "R1";
    logic [31:0] mw [256];
    logic        m_en;
    logic [3:0]  m_nb;
    logic [5:0]  m_off;
    logic [8:0]  expq [$];
    logic [8:0]  e_b;
    logic [7:0]  pkt [PKT_LEN];

    task automatic check(input bit ok, input string r, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, req, "unexpected output byte", {out_sop, out_data}, 0);
            end else begin
                e_b = expq.pop_front();
                check({out_sop, out_data} == e_b, req, "output byte", {out_sop, out_data}, e_b);
            end
        end
    end

    function automatic int model_pid();
        logic [63:0] w, t;
        logic [12:0] m;
        w = '0;
        for (int i = 0; i < 8; i++) w = {w[55:0], pkt[i]};
        t = w >> m_off;
        m = (m_nb >= 4'd13) ? 13'h1FFF : 13'((32'd1 << m_nb) - 1);
        return int'(t[12:0] & m);
    endfunction

    function automatic bit model_pass();
        int p;
        p = model_pid();
        return !m_en || mw[p / 32][p % 32];
    endfunction

    task automatic apply_cfg(input logic [15:0] cw);
        m_en = cw[15]; m_nb = cw[11:8]; m_off = cw[5:0];
    endtask

    task automatic fill_rand();
        for (int i = 0; i < PKT_LEN; i++) pkt[i] = 8'($urandom);
    endtask

    // PID placement for width 13 at offset 40: bytes 1 and 2
    task automatic fill_pid(input int pid);
        fill_rand();
        pkt[1] = {pkt[1][7:5], 5'(pid >> 8)};
        pkt[2] = 8'(pid);
    endtask

    task automatic tbl_wr(input logic [7:0] a, input logic [31:0] d);
        tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
        @(posedge clk); #2;
        tbl_we = 1'b0;
        mw[a] = d;
    endtask

    task automatic cfg_wr(input logic [15:0] cw);
        cfg_we = 1'b1; cfg_wdata = cw;
        @(posedge clk); #2;
        cfg_we = 1'b0;
        apply_cfg(cw);
    endtask

    task automatic send(input int wr_at, input logic [7:0] wa, input logic [31:0] wd,
                        input int cfg_at, input logic [15:0] cw, input bit gaps);
        if (model_pass())
            for (int i = 0; i < PKT_LEN; i++) expq.push_back({i == 0, pkt[i]});
        for (int i = 0; i < PKT_LEN; i++) begin
            in_valid = 1'b1; in_sop = (i == 0); in_data = pkt[i];
            tbl_we = (i == wr_at); tbl_addr = wa; tbl_wdata = wd;
            cfg_we = (i == cfg_at); cfg_wdata = cw;
            @(posedge clk); #2;
            in_valid = 1'b0; in_sop = 1'b0; tbl_we = 1'b0; cfg_we = 1'b0;
            if (gaps && $urandom_range(0, 3) == 0) begin
                @(posedge clk); #2;
            end
        end
        if (wr_at >= 0) mw[wa] = wd;
        if (cfg_at >= 0) apply_cfg(cw);
    endtask

    task automatic plain(input bit gaps);
        send(-1, 8'd0, 32'd0, -1, 16'd0, gaps);
    endtask

    task automatic drain(input string r);
        repeat (30) @(posedge clk);
        #2;
        check(expq.size() == 0, r, "forwarded bytes missing", expq.size(), 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) mw[i] = '0;
        apply_cfg(16'h8D28);   // reset configuration: enable, width 13, offset 40
        repeat (3) @(posedge clk);
        #2;
        check(out_valid == 1'b0, "R1", "out_valid during reset", out_valid, 0);
        rst = 1'b0;
        @(posedge clk); #2;
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R1 / R4: zero table with filtering enabled drops everything
        req = "R4";
        fill_pid(13'h0100); plain(1'b0);
        fill_pid(13'h1FFF); plain(1'b1);
        drain("R4");

        // R3: word/bit mapping, including the last PID
        req = "R3";
        tbl_wr(8'd8, 32'h0000_0001);
        fill_pid(256); plain(1'b0);
        fill_pid(257); plain(1'b0);
        tbl_wr(8'd255, 32'h8000_0000);
        fill_pid(8191); plain(1'b1);
        fill_pid(8190); plain(1'b0);
        drain("R3");

        // R2: other slices, including one running past bit 63
        req = "R2";
        cfg_wr(16'h8800);      // width 8, offset 0: PID is byte 7
        tbl_wr(8'd2, 32'h0020_0000);
        fill_rand(); pkt[7] = 8'h55; plain(1'b0);
        fill_rand(); pkt[7] = 8'h56; plain(1'b0);
        cfg_wr(16'h843C);      // width 4, offset 60
        tbl_wr(8'd0, 32'h0000_0008);
        fill_rand(); pkt[0] = 8'h3A; plain(1'b0);
        fill_rand(); pkt[0] = 8'h4A; plain(1'b0);
        cfg_wr(16'h8D3A);      // width 13, offset 58: only 6 bits remain
        fill_rand(); pkt[0] = 8'h0C; plain(1'b0);
        fill_rand(); pkt[0] = 8'h10; plain(1'b1);
        drain("R2");

        // R7: width above PID_W, and a mid-packet configuration change
        req = "R7";
        cfg_wr(16'h8F28);      // width 15, offset 40
        tbl_wr(8'd8, 32'h0000_0001);
        fill_pid(256); plain(1'b0);
        fill_pid(300); send(-1, 8'd0, 32'd0, 3, 16'h0D28, 1'b0);
        fill_pid(300); plain(1'b0);
        fill_pid(300); send(-1, 8'd0, 32'd0, 0, 16'h8D28, 1'b0);
        fill_pid(300); plain(1'b0);
        drain("R7");

        // R5: disable passes all
        req = "R5";
        cfg_wr(16'h0D28);
        for (int k = 0; k < 4; k++) begin fill_rand(); plain(1'b1); end
        drain("R5");

        // R8: table writes inside and after the header window
        req = "R8";
        cfg_wr(16'h8D28);
        tbl_wr(8'd20, 32'h0);
        fill_pid(20 * 32 + 5); send(2, 8'd20, 32'h0000_0020, -1, 16'd0, 1'b0);
        fill_pid(20 * 32 + 5); send(0, 8'd21, 32'h0000_0001, -1, 16'd0, 1'b1);
        fill_pid(21 * 32);     send(10, 8'd21, 32'h0, -1, 16'd0, 1'b0);
        fill_pid(21 * 32);     plain(1'b0);
        drain("R8");

        // R9: stray bytes outside a packet are ignored
        req = "R9";
        cfg_wr(16'h0D28);
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1; in_sop = 1'b0; in_data = 8'(8'hA0 + i);
            @(posedge clk); #2;
        end
        in_valid = 1'b0;
        fill_rand(); plain(1'b0);
        drain("R9");

        // R10: gapless forwarded packets
        req = "R10";
        for (int k = 0; k < 20; k++) begin fill_rand(); plain(1'b0); end
        drain("R10");

        // R6: random mix of traffic, table and configuration writes
        req = "R6";
        cfg_wr(16'h8D28);
        for (int i = 0; i < 256; i++) tbl_wr(8'(i), 32'($urandom));
        for (int k = 0; k < 250; k++) begin
            int wat, cat;
            logic [15:0] cw;
            if ($urandom_range(0, 4) == 0) tbl_wr(8'($urandom), 32'($urandom));
            if ($urandom_range(0, 9) == 0)
                cfg_wr({($urandom_range(0, 4) != 0), 3'b0, 4'($urandom), 2'b0, 6'($urandom)});
            wat = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, PKT_LEN - 1)) : -1;
            cat = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, PKT_LEN - 1)) : -1;
            cw  = {($urandom_range(0, 4) != 0), 3'b0, 4'($urandom), 2'b0, 6'($urandom)};
            fill_rand();
            send(wat, 8'($urandom), 32'($urandom), cat, cw, $urandom_range(0, 1) == 1);
        end
        drain("R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule